// File: doc/BRIEF.md
# Pseudocarry Lookahead Adder

This block is a purely combinational binary adder. It sums two operands and a carry-in and gives a sum of the same width plus a carry-out. Its lookahead tree does not pass true group carries. It passes a pseudocarry instead: the true carry with the leading propagate factored out. The tree also carries a group propagate term that is shifted one bit lower. Each true carry is rebuilt only at the point where a sum bit is formed, by ANDing the pseudocarry with the local propagate.

For every bit, the block forms a generate (AND), a propagate (OR) and a half-sum (XOR). The carry-in enters the tree as one extra position below bit 0, with a generate equal to the carry-in and a propagate of 1. This keeps the prefix tree uniform. The first level merges neighbouring positions into 2-bit pseudocarry groups of the form `g[k] | g[k-1]`. The following levels double the span at each step until every position covers all lower bits and the carry-in. The block has no clock and no state. The host logic registers the outputs where its timing needs it.

Top module: `ling_adder`

## Requirements
- R1: For any operands and carry-in, `{cout, sum}` equals `a + b + cin` computed at WIDTH+1 bits (default WIDTH = 32).
- R2: The carry-in adds exactly one at bit 0. With `a` all ones, `b` zero and `cin` = 1, `sum` is all zeros and `cout` is 1.
- R3: `cout` is 1 only if at least one of `a[WIDTH-1]` and `b[WIDTH-1]` is 1.
- R4: When `a` equals `b`, no bit propagates without generating. The result is `sum = {a[WIDTH-2:0], cin}` and `cout = a[WIDTH-1]`.
- R5: When every bit propagates (`b` equals the bitwise inverse of `a`), a carry-in of 0 gives `sum` all ones with `cout` 0. A carry-in of 1 gives `sum` all zeros with `cout` 1.
- R6: The outputs depend only on the present inputs. They reach their final value within the same clock period as an input change, and zero inputs give zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
A fixed table of operand pairs exercises each way a carry can start and travel:
- Equal operands give generate-only chains with no propagation.
- Complementary operands give a chain that propagates across the whole width, which shows whether the carry-in reaches the top.
- A single generate at bit 0 beneath a run of propagates shows whether the upper spans pick up a low generate through the shifted group-propagate term.
- Carries that stop partway through the word would expose a merge at the wrong distance in one tree level.

Random vectors with both carry-in values follow the table. They cover mixed patterns that the table misses.

// File: rtl/ling_pkg.sv
// Package: ling_pkg
// Shared sizing helpers for the pseudocarry adder.
// Assumes tree positions are numbered with the carry-in at position 0.
package ling_pkg;
    // Number of prefix levels needed to cover a given count of positions.
    function automatic int unsigned tree_levels(input int unsigned positions);
        return (positions <= 1) ? 1 : $clog2(positions);
    endfunction
endpackage

// File: rtl/ling_bit_cells.sv
// Module: ling_bit_cells
// Forms the per-bit generate (AND), propagate (OR) and half-sum (XOR).
// Assumes nothing about the operands; purely combinational.
module ling_bit_cells #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] half
);
    // Per-bit primitive terms.
    always_comb begin
        gen  = op_a & op_b;
        prop = op_a | op_b;
        half = op_a ^ op_b;
    end

    // A generate must imply a propagate, and the half-sum must be propagate without generate.
    always_comb begin
        p_gen_in_prop_r1: assert ((gen & ~prop) == '0)
            else $error("generate outside propagate");
        p_half_split_r1: assert (half == (prop & ~gen))
            else $error("half-sum inconsistent with generate/propagate");
    end
endmodule

// File: rtl/ling_merge_level.sv
// Module: ling_merge_level
// One prefix level. Each position at index j >= DIST merges with position j-DIST.
// The first level (FIRST=1) forms the 2-bit pseudocarry h[j] | h[j-1] directly.
// Later levels use h_hi | i_hi & h_lo. Group propagates multiply.
// Assumes positions below DIST already span down to position 0.
module ling_merge_level #(
    parameter int unsigned N     = 33,
    parameter int unsigned DIST  = 1,
    parameter bit          FIRST = 1'b0
) (
    input  logic [N-1:0] h_in,
    input  logic [N-1:0] i_in,
    output logic [N-1:0] h_out,
    output logic [N-1:0] i_out
);
    for (genvar j = 0; j < N; j++) begin : g_pos
        if (j < DIST) begin : g_pass
            // Group already complete: pass through.
            assign h_out[j] = h_in[j];
            assign i_out[j] = i_in[j];
        end else if (FIRST) begin : g_pair
            // Two-bit pseudocarry: the lower generate needs no propagate.
            assign h_out[j] = h_in[j] | h_in[j-DIST];
            assign i_out[j] = i_in[j] & i_in[j-DIST];
        end else begin : g_merge
            // General merge of an upper and a lower group.
            assign h_out[j] = h_in[j] | (i_in[j] & h_in[j-DIST]);
            assign i_out[j] = i_in[j] & i_in[j-DIST];
        end
    end
endmodule

// File: rtl/ling_prefix_tree.sv
// Module: ling_prefix_tree
// Parallel-prefix tree of pseudocarry (h) and shifted group propagate (i).
// Input position j carries generate ge[j] and local propagate pe[j].
// Position 0 is the carry-in.
// Output h_all[j] is the pseudocarry spanning positions j down to 0.
module ling_prefix_tree
    import ling_pkg::*;
#(
    parameter int unsigned N = 33
) (
    input  logic [N-1:0] ge,
    input  logic [N-1:0] pe,
    output logic [N-1:0] h_all
);
    localparam int unsigned LEVELS = tree_levels(N);

    logic [N-1:0] h_lvl [LEVELS+1];
    logic [N-1:0] i_lvl [LEVELS+1];

    // Level 0: single positions. The group propagate sits one position lower.
    assign h_lvl[0] = ge;
    assign i_lvl[0] = {pe[N-2:0], 1'b1};

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        ling_merge_level #(
            .N    (N),
            .DIST (1 << l),
            .FIRST(l == 0)
        ) u_level (
            .h_in (h_lvl[l]),
            .i_in (i_lvl[l]),
            .h_out(h_lvl[l+1]),
            .i_out(i_lvl[l+1])
        );
    end

    assign h_all = h_lvl[LEVELS];

    // The serial pseudocarry recurrence H[j] = ge[j] | pe[j-1]&H[j-1] must hold.
    // The full-span propagate must equal the product of all lower local propagates.
    always_comb begin
        logic run;
        p_h_base_r1: assert (h_all[0] == ge[0]) else $error("pseudocarry base wrong");
        run = 1'b1;
        for (int j = 1; j < int'(N); j++) begin
            p_h_rec_r1: assert (h_all[j] == (ge[j] | (pe[j-1] & h_all[j-1])))
                else $error("pseudocarry recurrence broken at %0d", j);
            run = run & pe[j-1];
            p_i_span_r5: assert (i_lvl[LEVELS][j] == run)
                else $error("group propagate wrong at %0d", j);
        end
    end
endmodule

// File: rtl/ling_sum_stage.sv
// Module: ling_sum_stage
// Rebuilds the true carries as pe & h and forms the sum bits and carry-out.
// Assumes pe[0] = 1 for the carry-in position.
module ling_sum_stage #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] half,
    input  logic [WIDTH:0]   pe,
    input  logic [WIDTH:0]   h_all,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] carry;

    // True carry at each position: local propagate times pseudocarry.
    always_comb carry = pe & h_all;

    // The sum bit uses the carry from the position below. The top carry leaves the block.
    always_comb begin
        sum  = half ^ carry[WIDTH-1:0];
        cout = carry[WIDTH];
    end

    // A true carry always implies its pseudocarry.
    always_comb begin
        p_carry_in_h_r1: assert ((carry & ~h_all) == '0)
            else $error("carry without pseudocarry");
    end
endmodule

// File: rtl/ling_adder.sv
// Module: ling_adder (top)
// Combinational pseudocarry lookahead adder: {cout, sum} = a + b + cin.
// The carry-in is tree position 0 (generate = cin, propagate = 1).
// Bit k of the operands is position k+1.
module ling_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned N = WIDTH + 1;

    logic [WIDTH-1:0] gen, prop, half;
    logic [N-1:0]     ge, pe, h_all;

    ling_bit_cells #(.WIDTH(WIDTH)) u_cells (
        .op_a(a),
        .op_b(b),
        .gen (gen),
        .prop(prop),
        .half(half)
    );

    // Extend the position vectors with the carry-in at position 0.
    always_comb begin
        ge = {gen, cin};
        pe = {prop, 1'b1};
    end

    ling_prefix_tree #(.N(N)) u_tree (
        .ge   (ge),
        .pe   (pe),
        .h_all(h_all)
    );

    ling_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .half (half),
        .pe   (pe),
        .h_all(h_all),
        .sum  (sum),
        .cout (cout)
    );

    // Arithmetic result and the carry-out condition at the ports.
    always_comb begin
        p_arith_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("sum mismatch");
        p_cout_needs_top_r3: assert (!cout || a[WIDTH-1] || b[WIDTH-1])
            else $error("carry-out without top propagate");
    end
endmodule

// File: tb/ling_adder_tb.sv
// Bench: ling_adder_tb_top. A table of vectors, then random and directed checks.
module ling_adder_tb_top;
    localparam int unsigned W = 32;
    localparam int NV = 12;

    // Stimulus table: operand a, operand b, carry-in.
    localparam logic [W-1:0] TA [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678,
        32'h8000_0000, 32'hAAAA_AAAA, 32'h0000_0001, 32'h7FFF_FFFF,
        32'hDEAD_BEEF, 32'h0000_FFFF, 32'hF0F0_F0F0, 32'h8000_0001};
    localparam logic [W-1:0] TB [NV] = '{
        32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678,
        32'h8000_0000, 32'h5555_5555, 32'h7FFF_FFFF, 32'h0000_0001,
        32'h2152_4110, 32'h0000_0001, 32'h0F0F_0F0F, 32'h7FFF_FFFF};
    localparam logic TC [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                                 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    logic         clk = 1'b0;
    logic [W-1:0] a, b, sum;
    logic         cin, cout;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #5 clk = ~clk;

    ling_adder #(.WIDTH(W)) dut_i (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    // Compare one result with an expected value.
    task automatic check(input string req, input logic [W:0] exp);
        checks++;
        if ({cout, sum} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, a, b, cin, {cout, sum}, exp);
        end
    endtask

    // Drive one vector on the rising edge and sample it on the falling edge.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] va, input logic [W-1:0] vb,
                                           input logic vc);
        return {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    endfunction

    initial begin
        a = '0; b = '0; cin = 1'b0;
        // R6: zero inputs give zero outputs in the same period.
        @(negedge clk);
        check("R6", '0);

        // R1: table walk.
        for (int k = 0; k < NV; k++) begin
            apply(TA[k], TB[k], TC[k]);
            check("R1", ref_add(TA[k], TB[k], TC[k]));
        end

        // R2: carry-in only.
        apply('1, '0, 1'b1);
        check("R2", {1'b1, {W{1'b0}}});
        apply('0, '0, 1'b1);
        check("R2", {{W{1'b0}}, 1'b1});

        // R4: equal operands shift left with cin in bit 0.
        apply(32'hC3A5_0F96, 32'hC3A5_0F96, 1'b1);
        check("R4", {32'hC3A5_0F96, 1'b1});
        apply(32'h5A5A_5A5A, 32'h5A5A_5A5A, 1'b0);
        check("R4", {32'h5A5A_5A5A, 1'b0});

        // R5: full-width propagate.
        apply(32'h1357_9BDF, ~32'h1357_9BDF, 1'b0);
        check("R5", {1'b0, {W{1'b1}}});
        apply(32'h1357_9BDF, ~32'h1357_9BDF, 1'b1);
        check("R5", {1'b1, {W{1'b0}}});

        // R3: no top bits set means no carry-out, even with all lower bits set.
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        check("R3", {1'b0, 32'hFFFF_FFFF});

        // R6: output follows an input change within one period, with no clock needed.
        apply(32'h0000_00FF, 32'h0000_0001, 1'b0);
        check("R6", 33'h0_0000_0100);

        // R1: random vectors.
        for (int k = 0; k < 2000; k++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = $urandom;
            rb = $urandom;
            rc = 1'(k % 2);
            apply(ra, rb, rc);
            check("R1", ref_add(ra, rb, rc));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule